// File: doc/BRIEF.md
# SSI Position Transmitter (Measuring-System Side)

This block is the encoder end of a synchronous-serial position link. An external controller drives a clock line. The block captures an absolute position word on the controller's first falling clock edge. It then shifts that word out one bit per rising edge on a single data line, most significant bit first. Every event is taken from the system clock. The controller clock is brought in through a synchronizer, and the block acts only on the edges it detects there.

The frame length can be set. The position field can be sent as plain binary or as Gray code. Up to three trailing status slots can replace the lowest bits of the frame. Each slot carries one of four things: the error flag, the warning flag, an even-parity bit over the position field, or a constant zero.

After the last bit the block holds the line low for a programmable recovery time counted in system clocks. Any controller clock edge during that time restarts the count. When the count runs out the line goes high, and only then can a new frame start.

Top module: `ssi_pos_tx`

## Requirements
- R1: While reset is high, and after it is released, the data line is high and the block is idle.
- R2: A level change on the controller clock that is first sampled at system edge n acts on the data line at system edge n+2.
- R3: A falling controller edge while idle starts a frame. At that edge the block captures the position, error, warning, length, coding, slot and recovery settings. Input changes after that edge do not alter the frame in progress.
- R4: Each rising controller edge in a frame drives the next bit, most significant first. The first rising edge after the start drives bit L-1 and rising edge number L drives bit 0, where L is the frame length.
- R5: The frame length L is taken from the length setting when that setting is 1..MAX_BITS. A setting of 0, or of more than MAX_BITS, gives L = MAX_BITS.
- R6: The position field is the F = L-K low bits of the position, where K is the slot count. With the Gray setting at 1 the field is sent as f ^ (f >> 1). With it at 0 the field is sent as plain binary.
- R7: A slot count K (0..3; clamped to L-1) makes the last K bits of the frame status slots. Slot 1 is the last bit, slot 2 the one before it and slot 3 the one before that. Slot s takes its kind from kind bits [2s-1:2s-2]: 0 sends the error flag, 1 the warning flag, 2 parity, 3 a constant 0.
- R8: The parity slot is the XOR of the F transmitted field bits, so the field together with this bit holds an even number of ones.
- R9: Rising edge L+1 drives the line low. With no further controller edges the line stays low for exactly T system cycles and then goes high, where T is the recovery setting. A setting of 0 acts as 1.
- R10: Any controller edge, rising or falling, that is detected during recovery restarts the full T-cycle low period.
- R11: A falling controller edge during recovery does not start a frame. A rising edge after the line has returned high, with no falling edge in between, leaves the line high.
- R12: Falling edges within a frame have no effect on the data line. The data line is high whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ssi_clk_i | input | 1 | Controller clock line, asynchronous to clk |
| pos_i | input | MAX_BITS | Absolute position, right-aligned |
| err_i | input | 1 | Error status flag |
| warn_i | input | 1 | Warning status flag |
| cfg_len_i | input | $clog2(MAX_BITS+1) | Frame length in bits |
| cfg_gray_i | input | 1 | 1 selects Gray coding for the position field |
| cfg_sb_cnt_i | input | 2 | Number of trailing status slots (0..3) |
| cfg_sb_kind_i | input | 6 | Kind of each slot, two bits per slot, slot 1 in [1:0] |
| cfg_tm_i | input | TM_W | Recovery time in system clocks |
| ssi_data_o | output | 1 | Serial data line, registered |

## Verification
A wrong internal state shows on the data line. A bad shift register or bit counter sends a wrong bit or a wrong number of bits, and this appears within one controller clock period. A wrong recovery count moves the rising edge at the end of recovery earlier or later by some number of system cycles. A wrong state encoding makes the line start or stop a frame at a controller edge where it should not. Because of this, the bench compares the line against a reference model on every system clock. This catches timing errors down to a single cycle, as well as errors in bit content.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;

  // Transmitter phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_RECOV = 2'd2
  } tx_state_e;

  // Content selector of one trailing status slot
  typedef enum logic [1:0] {
    SB_ERR  = 2'd0,
    SB_WARN = 2'd1,
    SB_PAR  = 2'd2,
    SB_ZERO = 2'd3
  } sb_kind_e;

  localparam int unsigned NUM_SB = 3;

endpackage

// File: rtl/ssi_edge_sync.sv
module ssi_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ssi_clk_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Resting level of the controller clock is high, so reset to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ssi_clk_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/ssi_word_build.sv
module ssi_word_build
  import ssi_tx_pkg::*;
#(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic [MAX_BITS-1:0] pos_i,
  input  logic                err_i,
  input  logic                warn_i,
  input  logic [LEN_W-1:0]    cfg_len_i,
  input  logic                cfg_gray_i,
  input  logic [1:0]          cfg_sb_cnt_i,
  input  logic [2*NUM_SB-1:0] cfg_sb_kind_i,
  output logic [MAX_BITS-1:0] word_o,
  output logic [LEN_W-1:0]    len_o
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BITS);

  logic [LEN_W-1:0]    len_eff;
  logic [LEN_W-1:0]    sb_n;
  logic [LEN_W-1:0]    fld_w;
  logic [LEN_W-1:0]    pad;
  logic [MAX_BITS-1:0] fld_mask;
  logic [MAX_BITS-1:0] fld_bin;
  logic [MAX_BITS-1:0] fld_enc;
  logic [MAX_BITS-1:0] word_r;
  logic                fld_par;
  logic [NUM_SB-1:0]   sb_val;

  // Length and slot count, clamped to legal values
  always_comb begin
    len_eff = (cfg_len_i == '0 || cfg_len_i > MAX_LEN) ? MAX_LEN : cfg_len_i;
    sb_n    = LEN_W'(cfg_sb_cnt_i);
    if (sb_n >= len_eff) sb_n = len_eff - 1'b1;
    fld_w   = len_eff - sb_n;
    pad     = MAX_LEN - len_eff;
  end

  always_comb begin
    for (int i = 0; i < MAX_BITS; i++) begin
      fld_mask[i] = (i < int'(fld_w));
    end
  end

  // Field coding and parity
  always_comb begin
    fld_bin = pos_i & fld_mask;
    fld_enc = cfg_gray_i ? (fld_bin ^ (fld_bin >> 1)) : fld_bin;
    fld_par = ^fld_enc;
  end

  // One selector per status slot
  for (genvar g = 0; g < NUM_SB; g++) begin : g_slot
    sb_kind_e kind;
    logic     slot_bit;
    assign kind = sb_kind_e'(cfg_sb_kind_i[2*g +: 2]);
    always_comb begin
      case (kind)
        SB_ERR:  slot_bit = err_i;
        SB_WARN: slot_bit = warn_i;
        SB_PAR:  slot_bit = fld_par;
        default: slot_bit = 1'b0;
      endcase
    end
    assign sb_val[g] = (LEN_W'(g) < sb_n) & slot_bit;
  end

  // Assemble and left-align so the first bit sent is the top bit
  always_comb begin
    word_r = (fld_enc << sb_n) | {{(MAX_BITS-NUM_SB){1'b0}}, sb_val};
    word_o = word_r << pad;
    len_o  = len_eff;
  end

endmodule

// File: rtl/ssi_shift_ctrl.sv
module ssi_shift_ctrl
  import ssi_tx_pkg::*;
#(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned LEN_W    = $clog2(MAX_BITS + 1),
  parameter int unsigned TM_W     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic [MAX_BITS-1:0] word_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [TM_W-1:0]     cfg_tm_i,
  output logic                data_o,
  output tx_state_e           state_o
);

  localparam logic [TM_W-1:0] TM_ONE = TM_W'(1);

  tx_state_e           state_q;
  logic [MAX_BITS-1:0] sr_q;
  logic [LEN_W-1:0]    left_q;
  logic [TM_W-1:0]     tm_q;
  logic [TM_W-1:0]     cnt_q;
  logic [TM_W-1:0]     tm_eff;
  logic                data_q;

  always_comb tm_eff = (cfg_tm_i == '0) ? TM_ONE : cfg_tm_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      left_q  <= '0;
      tm_q    <= TM_ONE;
      cnt_q   <= '0;
      data_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          data_q <= 1'b1;
          if (fall_i) begin
            sr_q    <= word_i;
            left_q  <= len_i;
            tm_q    <= tm_eff;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (rise_i) begin
            if (left_q != '0) begin
              data_q <= sr_q[MAX_BITS-1];
              sr_q   <= {sr_q[MAX_BITS-2:0], 1'b0};
              left_q <= left_q - 1'b1;
            end else begin
              data_q  <= 1'b0;
              cnt_q   <= tm_q - 1'b1;
              state_q <= ST_RECOV;
            end
          end
        end
        ST_RECOV: begin
          if (rise_i || fall_i) begin
            cnt_q <= tm_q - 1'b1;
          end else if (cnt_q == '0) begin
            data_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o  = data_q;
  assign state_o = state_q;

endmodule

// File: rtl/ssi_pos_tx.sv
module ssi_pos_tx
  import ssi_tx_pkg::*;
#(
  parameter int unsigned MAX_BITS    = 32,
  parameter int unsigned TM_W        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ssi_clk_i,
  input  logic [MAX_BITS-1:0] pos_i,
  input  logic                err_i,
  input  logic                warn_i,
  input  logic [LEN_W-1:0]    cfg_len_i,
  input  logic                cfg_gray_i,
  input  logic [1:0]          cfg_sb_cnt_i,
  input  logic [2*NUM_SB-1:0] cfg_sb_kind_i,
  input  logic [TM_W-1:0]     cfg_tm_i,
  output logic                ssi_data_o
);

  logic                edge_rise;
  logic                edge_fall;
  logic [MAX_BITS-1:0] frame_word;
  logic [LEN_W-1:0]    frame_len;
  tx_state_e           tx_state;

  ssi_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .ssi_clk_i (ssi_clk_i),
    .rise_o    (edge_rise),
    .fall_o    (edge_fall)
  );

  ssi_word_build #(
    .MAX_BITS (MAX_BITS),
    .LEN_W    (LEN_W)
  ) u_build (
    .pos_i         (pos_i),
    .err_i         (err_i),
    .warn_i        (warn_i),
    .cfg_len_i     (cfg_len_i),
    .cfg_gray_i    (cfg_gray_i),
    .cfg_sb_cnt_i  (cfg_sb_cnt_i),
    .cfg_sb_kind_i (cfg_sb_kind_i),
    .word_o        (frame_word),
    .len_o         (frame_len)
  );

  ssi_shift_ctrl #(
    .MAX_BITS (MAX_BITS),
    .LEN_W    (LEN_W),
    .TM_W     (TM_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rise_i   (edge_rise),
    .fall_i   (edge_fall),
    .word_i   (frame_word),
    .len_i    (frame_len),
    .cfg_tm_i (cfg_tm_i),
    .data_o   (ssi_data_o),
    .state_o  (tx_state)
  );

endmodule

// File: rtl/ssi_pos_tx_chk.sv
module ssi_pos_tx_chk
  import ssi_tx_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      rise,
  input logic      fall,
  input tx_state_e state,
  input logic      data
);

  // R12
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> data);

  // R9
  recov_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECOV) |-> !data);

  // R3
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && fall) |=> (state == ST_SHIFT));

  // R12
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !fall) |=> (state == ST_IDLE));

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECOV && fall) |=> (state == ST_RECOV));

  // R10
  recov_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECOV && (rise || fall)) |=> (state == ST_RECOV && !data));

  // R4
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && !rise) |=> ($stable(data) && state == ST_SHIFT));

endmodule

bind ssi_pos_tx ssi_pos_tx_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .rise  (edge_rise),
  .fall  (edge_fall),
  .state (tx_state),
  .data  (ssi_data_o)
);

// File: tb/ssi_pos_tx_tb.sv
module ssi_pos_tx_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ssi_clk_i = 1'b1;
  logic [31:0] pos_i = '0;
  logic        err_i = 1'b0;
  logic        warn_i = 1'b0;
  logic [5:0]  cfg_len_i = 6'd16;
  logic        cfg_gray_i = 1'b0;
  logic [1:0]  cfg_sb_cnt_i = 2'd0;
  logic [5:0]  cfg_sb_kind_i = 6'd0;
  logic [15:0] cfg_tm_i = 16'd10;
  logic        ssi_data_o;

  int    n_chk = 0;
  int    n_fail = 0;
  int    wd = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  ssi_pos_tx u_dut (
    .clk           (clk),
    .rst           (rst),
    .ssi_clk_i     (ssi_clk_i),
    .pos_i         (pos_i),
    .err_i         (err_i),
    .warn_i        (warn_i),
    .cfg_len_i     (cfg_len_i),
    .cfg_gray_i    (cfg_gray_i),
    .cfg_sb_cnt_i  (cfg_sb_cnt_i),
    .cfg_sb_kind_i (cfg_sb_kind_i),
    .cfg_tm_i      (cfg_tm_i),
    .ssi_data_o    (ssi_data_o)
  );

  // Expected frame, right-aligned, from the requirements
  function automatic void ref_word(input logic [31:0] pos, input logic er, input logic wr,
                                   input logic [5:0] clen, input logic gray,
                                   input logic [1:0] kcnt, input logic [5:0] kinds,
                                   output logic [31:0] w, output int len);
    int k, fw;
    logic [31:0] f;
    logic par, v;
    len = (clen == 0 || clen > 32) ? 32 : int'(clen);
    k = int'(kcnt);
    if (k > len - 1) k = len - 1;
    fw = len - k;
    f = '0;
    for (int i = 0; i < fw; i++) f[i] = pos[i];
    if (gray) f = f ^ (f >> 1);
    par = 1'b0;
    for (int i = 0; i < fw; i++) par = par ^ f[i];
    w = f << k;
    for (int s = 1; s <= k; s++) begin
      case (kinds[2*s-1 -: 2])
        2'd0: v = er;
        2'd1: v = wr;
        2'd2: v = par;
        default: v = 1'b0;
      endcase
      w[s-1] = v;
    end
  endfunction

  // Behavioural reference model, advanced on every system clock
  logic h0, h1, h2, h3, mr, mf, mexp = 1'b1;
  int   ms = 0, mrem = 0, mtm = 1;
  bit   mq[$];

  always @(posedge clk) begin
    logic [31:0] w;
    int len;
    if (rst) begin
      h0 = 1'b1; h1 = 1'b1; h2 = 1'b1; h3 = 1'b1;
      ms = 0; mexp = 1'b1; mq.delete();
    end else begin
      h3 = h2; h2 = h1; h1 = h0; h0 = ssi_clk_i;
      mr = h2 & ~h3;
      mf = ~h2 & h3;
      case (ms)
        0: if (mf) begin
          ref_word(pos_i, err_i, warn_i, cfg_len_i, cfg_gray_i, cfg_sb_cnt_i, cfg_sb_kind_i, w, len);
          mq.delete();
          for (int i = len - 1; i >= 0; i--) mq.push_back(w[i]);
          mtm = (cfg_tm_i == 0) ? 1 : int'(cfg_tm_i);
          ms = 1;
        end
        1: if (mr) begin
          if (mq.size() > 0) mexp = mq.pop_front();
          else begin mexp = 1'b0; mrem = mtm; ms = 2; end
        end
        default: begin
          if (mr || mf) mrem = mtm;
          else begin
            mrem--;
            if (mrem == 0) begin mexp = 1'b1; ms = 0; end
          end
        end
      endcase
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (ssi_data_o !== mexp) begin
        n_fail++;
        $display("FAIL %s per-cycle data: actual %b expected %b at %0t", cur_req, ssi_data_o, mexp, $time);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      report();
    end
  end

  task automatic chk_bit(input string req, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s data line: actual %b expected %b", req, act, expv);
    end
  endtask

  task automatic chk_word(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s frame: actual %h expected %h", req, act, expv);
    end
  endtask

  // Start on a falling edge, then nrise rising edges; collect one bit per rise
  task automatic send_frame(input int nrise, input bit disturb, output logic [31:0] got);
    got = '0;
    @(negedge clk) ssi_clk_i = 1'b0;
    repeat (4) @(negedge clk);
    for (int r = 0; r < nrise; r++) begin
      ssi_clk_i = 1'b1;
      repeat (4) @(negedge clk);
      got = {got[30:0], ssi_data_o};
      if (disturb && r == 0) begin
        pos_i = ~pos_i; cfg_gray_i = ~cfg_gray_i; err_i = ~err_i;
      end
      if (r != nrise - 1) begin
        ssi_clk_i = 1'b0;
        repeat (4) @(negedge clk);
      end
    end
  endtask

  task automatic pulse();
    ssi_clk_i = 1'b0;
    repeat (4) @(negedge clk);
    ssi_clk_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Rising edge L+1, then let recovery run out
  task automatic end_frame(input int tm);
    pulse();
    if (tm > 3) chk_bit("R9 low after last bit", ssi_data_o, 1'b0);
    repeat (tm + 6) @(negedge clk);
    chk_bit("R9 high after recovery", ssi_data_o, 1'b1);
  endtask

  initial begin
    logic [31:0] got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    chk_bit("R1 after reset", ssi_data_o, 1'b1);
    repeat (5) @(negedge clk);
    chk_bit("R1 idle", ssi_data_o, 1'b1);

    // R2: latency, MSB 0 makes the first bit visible
    cur_req = "R2";
    cfg_len_i = 6'd8; pos_i = 32'h35; cfg_tm_i = 16'd10;
    ssi_clk_i = 1'b0;
    repeat (4) @(negedge clk);
    ssi_clk_i = 1'b1;
    repeat (2) @(negedge clk);
    chk_bit("R2 before latency", ssi_data_o, 1'b1);
    @(negedge clk);
    chk_bit("R2 at latency", ssi_data_o, 1'b0);
    repeat (1) @(negedge clk);
    for (int r = 1; r < 8; r++) pulse();
    end_frame(10);

    // R3/R4/R12: binary frame, inputs disturbed after start
    cur_req = "R4";
    cfg_len_i = 6'd16; pos_i = 32'h0000_A5C3; cfg_gray_i = 1'b0;
    send_frame(16, 1'b1, got);
    chk_word("R3/R4/R12 binary frame", got & 32'hFFFF, 32'hA5C3);
    end_frame(10);
    cfg_gray_i = 1'b0; err_i = 1'b0;

    // R6: Gray coding, upper position bits ignored
    cur_req = "R6";
    cfg_len_i = 6'd12; cfg_gray_i = 1'b1; pos_i = 32'hFFFF_F9B4;
    send_frame(12, 1'b0, got);
    chk_word("R6 gray frame", got & 32'hFFF, 32'hD6E);
    end_frame(10);
    cfg_gray_i = 1'b0;

    // R7/R8: three slots: error, warning, parity
    cur_req = "R7";
    cfg_len_i = 6'd16; cfg_sb_cnt_i = 2'd3; cfg_sb_kind_i = 6'b00_01_10;
    err_i = 1'b1; warn_i = 1'b0; pos_i = 32'h1A3;
    send_frame(16, 1'b0, got);
    chk_word("R7/R8 slot frame", got & 32'hFFFF, 32'hD1D);
    end_frame(10);

    // R8: even field gives parity 0
    cur_req = "R8";
    cfg_len_i = 6'd8; cfg_sb_cnt_i = 2'd1; cfg_sb_kind_i = 6'b00_00_10; pos_i = 32'h3C;
    send_frame(8, 1'b0, got);
    chk_word("R8 even parity", got & 32'hFF, 32'h78);
    end_frame(10);

    // R7: slot count clamped to L-1
    cur_req = "R7";
    cfg_len_i = 6'd2; cfg_sb_cnt_i = 2'd3; cfg_sb_kind_i = 6'd0; err_i = 1'b1; pos_i = 32'h0;
    send_frame(2, 1'b0, got);
    chk_word("R7 slot clamp", got & 32'h3, 32'h1);
    end_frame(10);
    cfg_sb_cnt_i = 2'd0; err_i = 1'b0;

    // R5: length 0 and over-range both give 32 bits
    cur_req = "R5";
    cfg_len_i = 6'd0; pos_i = 32'hDEAD_BEEF;
    send_frame(32, 1'b0, got);
    chk_word("R5 length zero", got, 32'hDEAD_BEEF);
    end_frame(10);
    cfg_len_i = 6'd40; pos_i = 32'h1234_5678;
    send_frame(32, 1'b0, got);
    chk_word("R5 length over range", got, 32'h1234_5678);
    end_frame(10);

    // R10: edges during recovery keep the line low
    cur_req = "R10";
    cfg_len_i = 6'd4; pos_i = 32'h5; cfg_tm_i = 16'd12;
    send_frame(4, 1'b0, got);
    chk_word("R10 short frame", got & 32'hF, 32'h5);
    pulse(); pulse(); pulse(); pulse();
    chk_bit("R10 low while clocked", ssi_data_o, 1'b0);
    repeat (6) @(negedge clk);
    chk_bit("R10 low before restart expires", ssi_data_o, 1'b0);
    repeat (12) @(negedge clk);
    chk_bit("R10 high after restart expires", ssi_data_o, 1'b1);

    // R11: fall in recovery does not start a frame
    cur_req = "R11";
    cfg_len_i = 6'd4; pos_i = 32'h0; cfg_tm_i = 16'd12;
    send_frame(4, 1'b0, got);
    pulse();
    ssi_clk_i = 1'b0;
    repeat (20) @(negedge clk);
    chk_bit("R11 high after recovery", ssi_data_o, 1'b1);
    ssi_clk_i = 1'b1;
    repeat (6) @(negedge clk);
    chk_bit("R11 rise in idle ignored", ssi_data_o, 1'b1);

    // R9: recovery setting 0 acts as one cycle
    cur_req = "R9";
    cfg_len_i = 6'd4; pos_i = 32'hA; cfg_tm_i = 16'd0;
    send_frame(4, 1'b0, got);
    chk_word("R9 frame before short recovery", got & 32'hF, 32'hA);
    end_frame(0);
    cfg_tm_i = 16'd10;

    cur_req = "R12";
    repeat (10) @(negedge clk);
    chk_bit("R12 idle at end", ssi_data_o, 1'b1);
    report();
  end

endmodule